// File: doc/BRIEF.md
# Operand-Capturing Reservation Station

This block sits in front of a single functional unit and holds a small pool of issued instructions waiting to run. Each incoming instruction carries an operation code and two operand slots. A slot arrives either holding its value or holding the tag of the unit that will later produce that value. The station watches a shared result broadcast bus. Any slot that is still waiting takes the broadcast data when the broadcast tag equals the slot's tag.

An entry whose two operands are both present becomes eligible to run. When the functional unit signals that it can take work, the station sends out the oldest eligible entry, at most one per cycle. It passes along that entry's own fixed tag, so the unit can later broadcast its result under that tag. Dispatch frees the entry at once. The issue side reads the tag that will be given to its next instruction from the station. It stalls while the station reports that it is full.

Top module: `rs_station`

## Requirements
- R1: An instruction is accepted on a clock edge where `issue_valid_i` is high and `full_o` is low. It goes to the free entry with the lowest index, and that entry's tag, STATION_BASE plus the index (1 to 4 by default), is shown on `issue_tag_o` while the station is not full.
- R2: An operand tag of 0 means the accompanying value is valid. A non-zero operand tag means the value is missing until a broadcast with that tag arrives.
- R3: In a cycle where `bc_valid_i` is high, every held operand slot still waiting on tag `bc_tag_i` stores `bc_data_i` and becomes present. This holds for any number of entries in the same cycle, and the captured value is the one later dispatched.
- R4: An instruction written in a cycle in which its awaited tag is being broadcast stores the broadcast data in that same edge.
- R5: `disp_valid_o` is high only when `fu_ready_i` is high and some entry has both operands present. It presents that entry's operation and operand values, and only one entry goes out per cycle.
- R6: When several entries are eligible, the one issued earliest is dispatched, and `disp_tag_o` carries its entry tag.
- R7: An entry becomes eligible no earlier than the cycle after it was written, or after it captured its last missing operand.
- R8: A dispatched entry is free from the following cycle and can be given to a new instruction under the same tag.
- R9: `full_o` is high exactly when every entry is occupied. While it is high, an asserted `issue_valid_i` writes nothing.
- R10: After reset, no entry is occupied, `full_o` and `disp_valid_o` are low, and `issue_tag_o` shows STATION_BASE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| issue_valid_i | input | 1 | Issue request |
| issue_op_i | input | 4 | Operation code of the issued instruction |
| issue_a_tag_i | input | 4 | Producer tag of operand A, 0 = value valid |
| issue_a_val_i | input | 32 | Value of operand A |
| issue_b_tag_i | input | 4 | Producer tag of operand B, 0 = value valid |
| issue_b_val_i | input | 32 | Value of operand B |
| issue_tag_o | output | 4 | Tag that the next accepted instruction receives |
| full_o | output | 1 | All entries occupied; issue must stall |
| bc_valid_i | input | 1 | Result broadcast present |
| bc_tag_i | input | 4 | Tag of the broadcast result |
| bc_data_i | input | 32 | Broadcast result value |
| fu_ready_i | input | 1 | Functional unit can accept an instruction |
| disp_valid_o | output | 1 | An instruction is handed to the unit this cycle |
| disp_op_o | output | 4 | Operation of the dispatched instruction |
| disp_a_o | output | 32 | Operand A of the dispatched instruction |
| disp_b_o | output | 32 | Operand B of the dispatched instruction |
| disp_tag_o | output | 4 | Entry tag under which the result will be broadcast |

## Verification
Two functions can meet in one cycle. An instruction can be written while the result it is waiting for is on the broadcast bus. An entry can also take its last operand while the unit is ready and another entry is being dispatched. The bench sets up both cases on purpose: it issues with a tag equal to the live broadcast, and it broadcasts to a waiting entry while `fu_ready_i` is high. Random traffic aims about half of all broadcasts at tags that are actually pending. A bench model judges each cycle: the captured value must reach the unit, no dispatch may appear in the capture cycle, and the entry must come out one cycle later in age order.

// File: rtl/rs_pkg.sv
package rs_pkg;
  localparam int unsigned RS_DATA_W = 32;
  localparam int unsigned RS_TAG_W  = 4;
  localparam int unsigned RS_OP_W   = 4;

  typedef logic [RS_DATA_W-1:0] data_t;
  typedef logic [RS_TAG_W-1:0]  tag_t;
  typedef logic [RS_OP_W-1:0]   op_t;

  typedef struct packed {
    tag_t  tag;   // 0: val holds the operand
    data_t val;
  } operand_t;

  function automatic operand_t snoop(operand_t s, logic bv, tag_t bt, data_t bd);
    operand_t r;
    r = s;
    if (bv && (s.tag != '0) && (s.tag == bt)) begin
      r.tag = '0;
      r.val = bd;
    end
    return r;
  endfunction
endpackage

// File: rtl/rs_entry.sv
module rs_entry
  import rs_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     alloc_i,
  input  op_t      op_i,
  input  operand_t a_i,
  input  operand_t b_i,
  input  logic     free_i,
  input  logic     bc_valid_i,
  input  tag_t     bc_tag_i,
  input  data_t    bc_data_i,
  output logic     busy_o,
  output logic     ready_o,
  output op_t      op_o,
  output data_t    a_val_o,
  output data_t    b_val_o
);
  logic     busy_q;
  op_t      op_q;
  operand_t a_q, b_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      op_q   <= '0;
      a_q    <= '0;
      b_q    <= '0;
    end else if (alloc_i) begin
      busy_q <= 1'b1;
      op_q   <= op_i;
      a_q    <= snoop(a_i, bc_valid_i, bc_tag_i, bc_data_i);
      b_q    <= snoop(b_i, bc_valid_i, bc_tag_i, bc_data_i);
    end else begin
      if (free_i) busy_q <= 1'b0;
      if (busy_q) begin
        a_q <= snoop(a_q, bc_valid_i, bc_tag_i, bc_data_i);
        b_q <= snoop(b_q, bc_valid_i, bc_tag_i, bc_data_i);
      end
    end
  end

  // readiness comes from registered slots only: capture shows next cycle
  assign busy_o  = busy_q;
  assign ready_o = busy_q && (a_q.tag == '0) && (b_q.tag == '0);
  assign op_o    = op_q;
  assign a_val_o = a_q.val;
  assign b_val_o = b_q.val;

  // R3
  a_snoop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !alloc_i && (a_q.tag != '0) && bc_valid_i && (bc_tag_i == a_q.tag))
    |=> (a_q.tag == '0) && (a_q.val == $past(bc_data_i)));

  // R4
  b_issue_snoop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alloc_i && (b_i.tag != '0) && bc_valid_i && (bc_tag_i == b_i.tag))
    |=> (b_q.tag == '0) && (b_q.val == $past(bc_data_i)));
endmodule

// File: rtl/rs_alloc.sv
module rs_alloc #(
  parameter int unsigned NUM_ENTRIES = 4,
  localparam int unsigned IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
  input  logic [NUM_ENTRIES-1:0] busy_i,
  output logic [IDX_W-1:0]       free_idx_o,
  output logic                   full_o
);
  always_comb begin
    free_idx_o = '0;
    for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
      if (!busy_i[i]) free_idx_o = IDX_W'(i);
    end
  end

  assign full_o = &busy_i;
endmodule

// File: rtl/rs_age_sel.sv
module rs_age_sel #(
  parameter int unsigned NUM_ENTRIES = 4,
  localparam int unsigned IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   alloc_i,
  input  logic [IDX_W-1:0]       alloc_idx_i,
  input  logic [NUM_ENTRIES-1:0] ready_i,
  input  logic                   enable_i,
  output logic [NUM_ENTRIES-1:0] grant_o,
  output logic                   grant_valid_o,
  output logic [IDX_W-1:0]       grant_idx_o
);
  // older_q[j][i] = entry j was written before entry i
  logic [NUM_ENTRIES-1:0] older_q [NUM_ENTRIES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int j = 0; j < NUM_ENTRIES; j++) older_q[j] <= '0;
    end else if (alloc_i) begin
      for (int j = 0; j < NUM_ENTRIES; j++) begin
        if (IDX_W'(j) == alloc_idx_i) older_q[j] <= '0;
        else older_q[j][alloc_idx_i] <= 1'b1;
      end
    end
  end

  for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_pick
    logic [NUM_ENTRIES-1:0] blockers;
    for (genvar j = 0; j < NUM_ENTRIES; j++) begin : g_col
      assign blockers[j] = (i != j) && ready_i[j] && older_q[j][i];
    end
    assign grant_o[i] = enable_i && ready_i[i] && (blockers == '0);
  end

  always_comb begin
    grant_idx_o = '0;
    for (int i = 0; i < NUM_ENTRIES; i++) begin
      if (grant_o[i]) grant_idx_o = IDX_W'(i);
    end
  end

  assign grant_valid_o = |grant_o;

  // R5
  grant_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant_o));
endmodule

// File: rtl/rs_station.sv
module rs_station
  import rs_pkg::*;
#(
  parameter int unsigned NUM_ENTRIES  = 4,
  parameter int unsigned STATION_BASE = 1,
  localparam int unsigned IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 issue_valid_i,
  input  logic [RS_OP_W-1:0]   issue_op_i,
  input  logic [RS_TAG_W-1:0]  issue_a_tag_i,
  input  logic [RS_DATA_W-1:0] issue_a_val_i,
  input  logic [RS_TAG_W-1:0]  issue_b_tag_i,
  input  logic [RS_DATA_W-1:0] issue_b_val_i,
  output logic [RS_TAG_W-1:0]  issue_tag_o,
  output logic                 full_o,
  input  logic                 bc_valid_i,
  input  logic [RS_TAG_W-1:0]  bc_tag_i,
  input  logic [RS_DATA_W-1:0] bc_data_i,
  input  logic                 fu_ready_i,
  output logic                 disp_valid_o,
  output logic [RS_OP_W-1:0]   disp_op_o,
  output logic [RS_DATA_W-1:0] disp_a_o,
  output logic [RS_DATA_W-1:0] disp_b_o,
  output logic [RS_TAG_W-1:0]  disp_tag_o
);
  logic [NUM_ENTRIES-1:0] busy, ready, grant;
  logic [IDX_W-1:0]       free_idx, grant_idx;
  logic                   accept, full;
  op_t                    e_op [NUM_ENTRIES];
  data_t                  e_a  [NUM_ENTRIES];
  data_t                  e_b  [NUM_ENTRIES];
  operand_t               in_a, in_b;

  assign in_a   = '{tag: issue_a_tag_i, val: issue_a_val_i};
  assign in_b   = '{tag: issue_b_tag_i, val: issue_b_val_i};
  assign accept = issue_valid_i && !full;

  rs_alloc #(.NUM_ENTRIES(NUM_ENTRIES)) u_alloc (
    .busy_i     (busy),
    .free_idx_o (free_idx),
    .full_o     (full)
  );

  for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_ent
    rs_entry u_ent (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .alloc_i    (accept && (free_idx == IDX_W'(i))),
      .op_i       (issue_op_i),
      .a_i        (in_a),
      .b_i        (in_b),
      .free_i     (grant[i]),
      .bc_valid_i (bc_valid_i),
      .bc_tag_i   (bc_tag_i),
      .bc_data_i  (bc_data_i),
      .busy_o     (busy[i]),
      .ready_o    (ready[i]),
      .op_o       (e_op[i]),
      .a_val_o    (e_a[i]),
      .b_val_o    (e_b[i])
    );
  end

  rs_age_sel #(.NUM_ENTRIES(NUM_ENTRIES)) u_sel (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .alloc_i       (accept),
    .alloc_idx_i   (free_idx),
    .ready_i       (ready),
    .enable_i      (fu_ready_i),
    .grant_o       (grant),
    .grant_valid_o (disp_valid_o),
    .grant_idx_o   (grant_idx)
  );

  assign full_o      = full;
  assign issue_tag_o = tag_t'(STATION_BASE) + tag_t'(free_idx);
  assign disp_op_o   = e_op[grant_idx];
  assign disp_a_o    = e_a[grant_idx];
  assign disp_b_o    = e_b[grant_idx];
  assign disp_tag_o  = tag_t'(STATION_BASE) + tag_t'(grant_idx);

  // R5
  fu_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    disp_valid_o |-> fu_ready_i);

  // R8
  busy_free_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    disp_valid_o |=> !busy[$past(grant_idx)]);

  // R9
  full_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && !disp_valid_o) |=> full_o);
endmodule

// File: tb/rs_station_tb.sv
module rs_station_tb;
  import rs_pkg::*;
  localparam int N = 4;
  localparam int BASE = 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic issue_valid, bc_valid, fu_ready;
  op_t issue_op;
  tag_t a_tag, b_tag, bc_tag, issue_tag, disp_tag;
  data_t a_val, b_val, bc_data, disp_a, disp_b;
  logic full, disp_valid;
  op_t disp_op;
  int total = 0, fails = 0;

  always #4 clk = ~clk;

  rs_station u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .issue_valid_i(issue_valid), .issue_op_i(issue_op),
    .issue_a_tag_i(a_tag), .issue_a_val_i(a_val),
    .issue_b_tag_i(b_tag), .issue_b_val_i(b_val),
    .issue_tag_o(issue_tag), .full_o(full),
    .bc_valid_i(bc_valid), .bc_tag_i(bc_tag), .bc_data_i(bc_data),
    .fu_ready_i(fu_ready),
    .disp_valid_o(disp_valid), .disp_op_o(disp_op),
    .disp_a_o(disp_a), .disp_b_o(disp_b), .disp_tag_o(disp_tag)
  );

  bit    m_busy [N];
  op_t   m_op [N];
  tag_t  m_at [N], m_bt [N];
  data_t m_av [N], m_bv [N];
  int    m_seq [N];
  int    seq_ctr = 0;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic int m_free();
    for (int i = 0; i < N; i++) if (!m_busy[i]) return i;
    return -1;
  endfunction

  function automatic int m_pick();
    int p = -1;
    for (int i = 0; i < N; i++)
      if (m_busy[i] && m_at[i] == 0 && m_bt[i] == 0 && (p < 0 || m_seq[i] < m_seq[p])) p = i;
    return p;
  endfunction

  task automatic step(input string req, input bit iv, input op_t op,
                      input tag_t at, input data_t av, input tag_t bt, input data_t bv,
                      input bit bcv, input tag_t bct, input data_t bcd, input bit fr);
    int f, p;
    issue_valid = iv; issue_op = op; a_tag = at; a_val = av; b_tag = bt; b_val = bv;
    bc_valid = bcv; bc_tag = bct; bc_data = bcd; fu_ready = fr;
    #1;
    f = m_free();
    p = fr ? m_pick() : -1;
    chk("R9", full, (f < 0));
    if (f >= 0) chk("R1", issue_tag, BASE + f);
    chk(req, disp_valid, (p >= 0));
    if (p >= 0) begin
      chk("R3", {disp_op, disp_a}, {m_op[p], m_av[p]});
      chk("R3", disp_b, m_bv[p]);
      chk("R6", disp_tag, BASE + p);
      m_busy[p] = 0;
    end
    for (int i = 0; i < N; i++) begin
      if (bcv && m_busy[i] && m_at[i] != 0 && m_at[i] == bct) begin m_at[i] = 0; m_av[i] = bcd; end
      if (bcv && m_busy[i] && m_bt[i] != 0 && m_bt[i] == bct) begin m_bt[i] = 0; m_bv[i] = bcd; end
    end
    if (iv && f >= 0) begin
      m_busy[f] = 1; m_op[f] = op; m_seq[f] = seq_ctr++;
      m_at[f] = at; m_av[f] = av; m_bt[f] = bt; m_bv[f] = bv;
      if (bcv && at != 0 && at == bct) begin m_at[f] = 0; m_av[f] = bcd; end
      if (bcv && bt != 0 && bt == bct) begin m_bt[f] = 0; m_bv[f] = bcd; end
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle(input string req, input bit fr);
    step(req, 0, '0, '0, '0, '0, '0, 0, '0, '0, fr);
  endtask

  function automatic tag_t rnd_tag();
    return ($urandom % 3 == 0) ? tag_t'(0) : tag_t'(1 + $urandom % 15);
  endfunction

  function automatic tag_t bc_pick();
    tag_t c [2*N];
    int n = 0;
    for (int i = 0; i < N; i++) if (m_busy[i]) begin
      if (m_at[i] != 0) c[n++] = m_at[i];
      if (m_bt[i] != 0) c[n++] = m_bt[i];
    end
    if (n > 0 && $urandom % 2 == 0) return c[$urandom % n];
    return tag_t'(1 + $urandom % 15);
  endfunction

  initial begin
    #1_000_000;
    fails++; total++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(32'd7);
    issue_valid = 0; issue_op = '0; a_tag = '0; a_val = '0; b_tag = '0; b_val = '0;
    bc_valid = 0; bc_tag = '0; bc_data = '0; fu_ready = 0;
    for (int i = 0; i < N; i++) m_busy[i] = 0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    // R10 reset state
    #1;
    chk("R10", {full, disp_valid}, 2'b00);
    chk("R10", issue_tag, BASE);
    @(negedge clk);

    // R2 pending operand blocks dispatch, R7 capture visible only next cycle
    step("R2", 1, 4'h3, 0, 32'h11, 4'd9, 32'hdead, 0, '0, '0, 1);
    idle("R2", 1);
    step("R7", 0, '0, '0, '0, '0, '0, 1, 4'd9, 32'h5555_aaaa, 1);
    idle("R7", 1);

    // R4 issue in the broadcast cycle of its tag
    step("R4", 1, 4'h5, 4'd6, 32'h0, 0, 32'h22, 1, 4'd6, 32'h1234_5678, 0);
    idle("R4", 1);

    // R6 age order: three ready entries then drain
    step("R6", 1, 4'h1, 0, 32'ha1, 0, 32'hb1, 0, '0, '0, 0);
    step("R6", 1, 4'h2, 0, 32'ha2, 0, 32'hb2, 0, '0, '0, 0);
    step("R6", 1, 4'h4, 0, 32'ha3, 0, 32'hb3, 0, '0, '0, 1);
    repeat (3) idle("R6", 1);

    // R9 fill, issue while full, release several waiters at once (R3)
    for (int k = 0; k < N; k++) step("R9", 1, op_t'(k), 4'd12, 32'h0, 0, k, 0, '0, '0, 0);
    step("R9", 1, 4'hf, 0, 32'h77, 0, 32'h88, 0, '0, '0, 0);
    step("R3", 0, '0, '0, '0, '0, '0, 1, 4'd12, 32'hcafe_f00d, 0);
    step("R8", 0, '0, '0, '0, '0, '0, 0, '0, '0, 1);
    #1;
    chk("R8", {full, issue_tag}, {1'b0, tag_t'(BASE)});
    step("R8", 1, 4'h9, 0, 32'h1, 0, 32'h2, 0, '0, '0, 0);
    repeat (5) idle("R8", 1);

    // random traffic
    for (int n = 0; n < 4000; n++) begin
      bit iv = ($urandom % 4) != 0;
      bit bcv = ($urandom % 2) != 0;
      step("R5", iv, op_t'($urandom), rnd_tag(), $urandom, rnd_tag(), $urandom,
           bcv, bc_pick(), $urandom, ($urandom % 3) != 0);
    end

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule